// File: doc/BRIEF.md
# Privileged Trap Entry Sequencer

This block performs the architectural side effects of taking a trap in a core that has user, supervisor and machine privilege levels plus a debug mode. When a trap request arrives it carries a cause word, the PC of the trapping instruction, an optional faulting address and a flag telling whether an external debugger is attached. In one clock edge the block decides where the trap is handled, redirects the fetch PC, saves the trap PC, cause and faulting address into the registers of the chosen level, stacks the old interrupt enable and privilege into the status word and moves to the new privilege.

The current privilege, the current status word, both delegation masks, both trap vectors and the current debug-cause state come in as inputs. The results leave as registered outputs that the surrounding core writes back. A one-cycle pulse tells the translation cache to flush when privilege changes, and another tells the memory system to drop any held load reservation.

Top module: `trap_entry_seq`

## Requirements
- R1: Bit XLEN-1 of the cause word marks an interrupt. For an interrupt the interrupt delegation mask is consulted; otherwise the exception delegation mask is consulted. In both cases the index is the cause with bit XLEN-1 cleared.
- R2: A trap goes to the supervisor handler only if three things hold: the current privilege is user (0) or supervisor (1), the index is below XLEN, and the selected mask has a 1 at that index. Every other trap goes to machine mode (privilege 3).
- R3: On supervisor entry the next PC becomes the supervisor vector, and the supervisor cause and trap PC are written. The supervisor faulting-address register is written only when the address-valid flag is set, and keeps its value otherwise.
- R4: On supervisor entry, status bit 5 receives the status bit whose position equals the old privilege, bit 8 receives the low bit of the old privilege, and bit 1 is cleared. The privilege becomes 1 and all other status bits are kept.
- R5: On machine entry, status bit 7 receives the status bit whose position equals the old privilege, bits 12:11 receive the old privilege, and bit 3 is cleared. The machine cause is written, the machine faulting address is written only when the address is valid, and the privilege becomes 3.
- R6: On machine entry, a nonzero debug cause input sends the next PC to the debug-ROM exception address and writes the trap PC to the debug PC, leaving the machine trap PC alone. Otherwise the next PC is the machine vector and the machine trap PC is written.
- R7: A non-interrupt breakpoint cause (3) with the debugger attached enters debug mode. The debug cause output becomes 1, the debug saved-privilege output takes the old privilege, and the privilege becomes 3. The debug PC takes the trap PC and the next PC becomes the debug-ROM start address. The status word passes through unchanged and no cause, trap-PC or faulting-address register is written.
- R8: The cycle after a trap, the redirect and reservation-release outputs pulse high for one cycle. The flush output pulses high in that cycle exactly when the new privilege differs from the old one.
- R9: Without a trap request all registered outputs hold their values and the three pulse outputs stay low.
- R10: After reset the privilege is 3, and the status, next PC, all trap registers and all pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid_i | input | 1 | Trap request this cycle |
| trap_cause_i | input | XLEN | Cause word, MSB set for interrupts |
| trap_epc_i | input | XLEN | PC of the trapping instruction |
| trap_addr_i | input | XLEN | Faulting address |
| trap_addr_valid_i | input | 1 | Faulting address is meaningful |
| dbg_attached_i | input | 1 | External debugger attached |
| cur_priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| status_i | input | XLEN | Current status word |
| edeleg_i | input | XLEN | Exception delegation mask |
| ideleg_i | input | XLEN | Interrupt delegation mask |
| stvec_i | input | XLEN | Supervisor trap vector |
| mtvec_i | input | XLEN | Machine trap vector |
| dbg_cause_i | input | DCAUSE_W | Current debug cause, nonzero while in debug mode |
| redirect_o | output | 1 | Pulse: next_pc_o is a new fetch target |
| next_pc_o | output | XLEN | Fetch redirect target |
| priv_o | output | 2 | New privilege |
| status_o | output | XLEN | New status word |
| sepc_o | output | XLEN | Supervisor trap PC |
| scause_o | output | XLEN | Supervisor cause |
| sbadaddr_o | output | XLEN | Supervisor faulting address |
| mepc_o | output | XLEN | Machine trap PC |
| mcause_o | output | XLEN | Machine cause |
| mbadaddr_o | output | XLEN | Machine faulting address |
| dpc_o | output | XLEN | Debug PC |
| dbg_cause_o | output | DCAUSE_W | Debug cause set on breakpoint entry |
| dbg_prv_o | output | 2 | Privilege saved on debug entry |
| tlb_flush_o | output | 1 | Pulse: privilege changed |
| resv_release_o | output | 1 | Pulse: drop load reservation |

## Verification
The sweep covers every legal old privilege, interrupts and exceptions, indices 0 through XLEN+1, and two delegation mask pairs. The two mask pairs differ bit by bit, so picking the wrong mask sends some index to the wrong handler, and the indices of XLEN and above show whether the range guard works. The debug-cause input, the address-valid flag and the debugger-attached flag toggle across the sweep. This separates the plain machine path from the debug-ROM exception path, shows whether the faulting-address registers really hold, and shows the breakpoint cause both diverting to debug mode and, with no debugger attached, being taken as an ordinary exception. The status inputs vary with the index, so each stacked enable bit is seen at both values.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int ST_SIE    = 1;
  localparam int ST_MIE    = 3;
  localparam int ST_SPIE   = 5;
  localparam int ST_MPIE   = 7;
  localparam int ST_SPP    = 8;
  localparam int ST_MPP_LO = 11;
  localparam int ST_MPP_HI = 12;

  typedef enum logic [1:0] {
    DEST_SUP      = 2'd0,
    DEST_MACH     = 2'd1,
    DEST_MACH_DBG = 2'd2,
    DEST_DEBUG    = 2'd3
  } dest_e;
endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_entry_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int BKPT_CAUSE = 3
) (
  input  logic [XLEN-1:0] cause_i,
  input  logic [1:0]      cur_priv_i,
  input  logic [XLEN-1:0] edeleg_i,
  input  logic [XLEN-1:0] ideleg_i,
  input  logic            dbg_active_i,
  input  logic            dbg_attached_i,
  output dest_e           dest_o
);
  localparam int              IW     = $clog2(XLEN);
  localparam logic [XLEN-1:0] LIM    = XLEN'(XLEN);
  localparam logic [XLEN-1:0] BKPT_W = XLEN'(BKPT_CAUSE);

  logic            is_intr;
  logic [XLEN-1:0] idx;
  logic [XLEN-1:0] mask;
  logic            in_range;
  logic            deleg_bit;
  logic            low_priv;
  logic            bkpt;

  always_comb begin
    is_intr   = cause_i[XLEN-1];
    idx       = {1'b0, cause_i[XLEN-2:0]};
    mask      = is_intr ? ideleg_i : edeleg_i;
    in_range  = idx < LIM;
    deleg_bit = in_range && mask[idx[IW-1:0]];
    low_priv  = (cur_priv_i == PRIV_U) || (cur_priv_i == PRIV_S);
    bkpt      = !is_intr && (idx == BKPT_W) && dbg_attached_i;
    if (bkpt)                       dest_o = DEST_DEBUG;
    else if (low_priv && deleg_bit) dest_o = DEST_SUP;
    else if (dbg_active_i)          dest_o = DEST_MACH_DBG;
    else                            dest_o = DEST_MACH;
  end
endmodule

// File: rtl/trap_status.sv
module trap_status
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  dest_e           dest_i,
  input  logic [1:0]      cur_priv_i,
  input  logic [XLEN-1:0] status_i,
  output logic [XLEN-1:0] status_o,
  output logic [1:0]      priv_o
);
  logic prev_ie;

  always_comb begin
    prev_ie  = status_i[cur_priv_i];
    status_o = status_i;
    priv_o   = PRIV_M;
    unique case (dest_i)
      DEST_SUP: begin
        status_o[ST_SPIE] = prev_ie;
        status_o[ST_SPP]  = cur_priv_i[0];
        status_o[ST_SIE]  = 1'b0;
        priv_o            = PRIV_S;
      end
      DEST_MACH, DEST_MACH_DBG: begin
        status_o[ST_MPIE]             = prev_ie;
        status_o[ST_MPP_HI:ST_MPP_LO] = cur_priv_i;
        status_o[ST_MIE]              = 1'b0;
        priv_o                        = PRIV_M;
      end
      default: begin
        status_o = status_i;
        priv_o   = PRIV_M;
      end
    endcase
  end
endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs
  import trap_entry_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int DCAUSE_W    = 3,
  parameter int DCAUSE_SWBP = 1,
  parameter int DBG_ROM     = 'h800,
  parameter int DBG_EXC     = 'h808
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fire_i,
  input  dest_e               dest_i,
  input  logic [XLEN-1:0]     cause_i,
  input  logic [XLEN-1:0]     epc_i,
  input  logic [XLEN-1:0]     addr_i,
  input  logic                addr_valid_i,
  input  logic [XLEN-1:0]     stvec_i,
  input  logic [XLEN-1:0]     mtvec_i,
  input  logic [1:0]          cur_priv_i,
  input  logic [XLEN-1:0]     status_nxt_i,
  input  logic [1:0]          priv_nxt_i,
  output logic                redirect_o,
  output logic [XLEN-1:0]     next_pc_o,
  output logic [1:0]          priv_o,
  output logic [XLEN-1:0]     status_o,
  output logic [XLEN-1:0]     sepc_o,
  output logic [XLEN-1:0]     scause_o,
  output logic [XLEN-1:0]     sbadaddr_o,
  output logic [XLEN-1:0]     mepc_o,
  output logic [XLEN-1:0]     mcause_o,
  output logic [XLEN-1:0]     mbadaddr_o,
  output logic [XLEN-1:0]     dpc_o,
  output logic [DCAUSE_W-1:0] dbg_cause_o,
  output logic [1:0]          dbg_prv_o,
  output logic                tlb_flush_o,
  output logic                resv_release_o
);
  localparam logic [XLEN-1:0]     ROM_W  = XLEN'(DBG_ROM);
  localparam logic [XLEN-1:0]     EXC_W  = XLEN'(DBG_EXC);
  localparam logic [DCAUSE_W-1:0] SWBP_W = DCAUSE_W'(DCAUSE_SWBP);

  logic to_sup, to_mach, to_mdbg, to_dbg;
  logic [XLEN-1:0] tgt_pc;

  always_comb begin
    to_sup  = fire_i && (dest_i == DEST_SUP);
    to_mach = fire_i && (dest_i == DEST_MACH);
    to_mdbg = fire_i && (dest_i == DEST_MACH_DBG);
    to_dbg  = fire_i && (dest_i == DEST_DEBUG);
    unique case (dest_i)
      DEST_SUP:      tgt_pc = stvec_i;
      DEST_MACH:     tgt_pc = mtvec_i;
      DEST_MACH_DBG: tgt_pc = EXC_W;
      default:       tgt_pc = ROM_W;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_o     <= 1'b0;
      tlb_flush_o    <= 1'b0;
      resv_release_o <= 1'b0;
      next_pc_o      <= '0;
      priv_o         <= PRIV_M;
      status_o       <= '0;
      sepc_o         <= '0;
      scause_o       <= '0;
      sbadaddr_o     <= '0;
      mepc_o         <= '0;
      mcause_o       <= '0;
      mbadaddr_o     <= '0;
      dpc_o          <= '0;
      dbg_cause_o    <= '0;
      dbg_prv_o      <= '0;
    end else begin
      redirect_o     <= fire_i;
      resv_release_o <= fire_i;
      tlb_flush_o    <= fire_i && (priv_nxt_i != cur_priv_i);
      if (fire_i) begin
        next_pc_o <= tgt_pc;
        priv_o    <= priv_nxt_i;
        status_o  <= status_nxt_i;
      end
      if (to_sup) begin
        sepc_o   <= epc_i;
        scause_o <= cause_i;
        if (addr_valid_i) sbadaddr_o <= addr_i;
      end
      if (to_mach || to_mdbg) begin
        mcause_o <= cause_i;
        if (addr_valid_i) mbadaddr_o <= addr_i;
      end
      if (to_mach) mepc_o <= epc_i;
      if (to_mdbg || to_dbg) dpc_o <= epc_i;
      if (to_dbg) begin
        dbg_cause_o <= SWBP_W;
        dbg_prv_o   <= cur_priv_i;
      end
    end
  end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_entry_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int DCAUSE_W    = 3,
  parameter int DCAUSE_SWBP = 1,
  parameter int BKPT_CAUSE  = 3,
  parameter int DBG_ROM     = 'h800,
  parameter int DBG_EXC     = 'h808
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                trap_valid_i,
  input  logic [XLEN-1:0]     trap_cause_i,
  input  logic [XLEN-1:0]     trap_epc_i,
  input  logic [XLEN-1:0]     trap_addr_i,
  input  logic                trap_addr_valid_i,
  input  logic                dbg_attached_i,
  input  logic [1:0]          cur_priv_i,
  input  logic [XLEN-1:0]     status_i,
  input  logic [XLEN-1:0]     edeleg_i,
  input  logic [XLEN-1:0]     ideleg_i,
  input  logic [XLEN-1:0]     stvec_i,
  input  logic [XLEN-1:0]     mtvec_i,
  input  logic [DCAUSE_W-1:0] dbg_cause_i,
  output logic                redirect_o,
  output logic [XLEN-1:0]     next_pc_o,
  output logic [1:0]          priv_o,
  output logic [XLEN-1:0]     status_o,
  output logic [XLEN-1:0]     sepc_o,
  output logic [XLEN-1:0]     scause_o,
  output logic [XLEN-1:0]     sbadaddr_o,
  output logic [XLEN-1:0]     mepc_o,
  output logic [XLEN-1:0]     mcause_o,
  output logic [XLEN-1:0]     mbadaddr_o,
  output logic [XLEN-1:0]     dpc_o,
  output logic [DCAUSE_W-1:0] dbg_cause_o,
  output logic [1:0]          dbg_prv_o,
  output logic                tlb_flush_o,
  output logic                resv_release_o
);
  dest_e           dest;
  logic [XLEN-1:0] status_nxt;
  logic [1:0]      priv_nxt;

  trap_route #(.XLEN(XLEN), .BKPT_CAUSE(BKPT_CAUSE)) u_route (
    .cause_i       (trap_cause_i),
    .cur_priv_i    (cur_priv_i),
    .edeleg_i      (edeleg_i),
    .ideleg_i      (ideleg_i),
    .dbg_active_i  (|dbg_cause_i),
    .dbg_attached_i(dbg_attached_i),
    .dest_o        (dest)
  );

  trap_status #(.XLEN(XLEN)) u_status (
    .dest_i    (dest),
    .cur_priv_i(cur_priv_i),
    .status_i  (status_i),
    .status_o  (status_nxt),
    .priv_o    (priv_nxt)
  );

  trap_state_regs #(
    .XLEN(XLEN), .DCAUSE_W(DCAUSE_W), .DCAUSE_SWBP(DCAUSE_SWBP),
    .DBG_ROM(DBG_ROM), .DBG_EXC(DBG_EXC)
  ) u_regs (
    .clk           (clk),
    .rst           (rst),
    .fire_i        (trap_valid_i),
    .dest_i        (dest),
    .cause_i       (trap_cause_i),
    .epc_i         (trap_epc_i),
    .addr_i        (trap_addr_i),
    .addr_valid_i  (trap_addr_valid_i),
    .stvec_i       (stvec_i),
    .mtvec_i       (mtvec_i),
    .cur_priv_i    (cur_priv_i),
    .status_nxt_i  (status_nxt),
    .priv_nxt_i    (priv_nxt),
    .redirect_o    (redirect_o),
    .next_pc_o     (next_pc_o),
    .priv_o        (priv_o),
    .status_o      (status_o),
    .sepc_o        (sepc_o),
    .scause_o      (scause_o),
    .sbadaddr_o    (sbadaddr_o),
    .mepc_o        (mepc_o),
    .mcause_o      (mcause_o),
    .mbadaddr_o    (mbadaddr_o),
    .dpc_o         (dpc_o),
    .dbg_cause_o   (dbg_cause_o),
    .dbg_prv_o     (dbg_prv_o),
    .tlb_flush_o   (tlb_flush_o),
    .resv_release_o(resv_release_o)
  );
endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            trap_valid_i,
  input logic            trap_addr_valid_i,
  input logic            dbg_attached_i,
  input logic [1:0]      cur_priv_i,
  input logic            redirect_o,
  input logic [1:0]      priv_o,
  input logic [XLEN-1:0] status_o,
  input logic [XLEN-1:0] sepc_o,
  input logic [XLEN-1:0] mepc_o,
  input logic [XLEN-1:0] sbadaddr_o,
  input logic [XLEN-1:0] mbadaddr_o,
  input logic            tlb_flush_o,
  input logic            resv_release_o
);
  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    trap_valid_i |=> (resv_release_o && redirect_o));

  p_flush_r8: assert property (@(posedge clk) disable iff (rst)
    trap_valid_i |=> (tlb_flush_o == (priv_o != $past(cur_priv_i))));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !trap_valid_i |=> (!resv_release_o && !redirect_o && !tlb_flush_o &&
                       $stable(priv_o) && $stable(sepc_o) && $stable(mepc_o)));

  p_mach_from_m_r2: assert property (@(posedge clk) disable iff (rst)
    (trap_valid_i && cur_priv_i == 2'd3) |=> (priv_o == 2'd3));

  p_mie_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (trap_valid_i && cur_priv_i == 2'd3 && !dbg_attached_i) |=> !status_o[3]);

  p_sie_clear_r4: assert property (@(posedge clk) disable iff (rst)
    trap_valid_i |=> (priv_o != 2'd1 || !status_o[1]));

  p_bad_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (trap_valid_i && !trap_addr_valid_i) |=>
      ($stable(sbadaddr_o) && $stable(mbadaddr_o)));
endmodule

bind trap_entry_seq trap_entry_seq_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/trap_entry_seq_bench.sv
`timescale 1ns/1ps
module trap_entry_seq_bench;
  localparam int XLEN = 32;
  localparam int DCW  = 3;
  localparam int ROM  = 'h800;
  localparam int EXC  = 'h808;
  localparam logic [31:0] STVEC = 32'h2000_0100;
  localparam logic [31:0] MTVEC = 32'h3000_0200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic            trap_valid_i = 0, trap_addr_valid_i = 0, dbg_attached_i = 0;
  logic [31:0]     trap_cause_i = 0, trap_epc_i = 0, trap_addr_i = 0;
  logic [1:0]      cur_priv_i = 3;
  logic [31:0]     status_i = 0, edeleg_i = 0, ideleg_i = 0;
  logic [31:0]     stvec_i = STVEC, mtvec_i = MTVEC;
  logic [DCW-1:0]  dbg_cause_i = 0;
  logic            redirect_o, tlb_flush_o, resv_release_o;
  logic [31:0]     next_pc_o, status_o, sepc_o, scause_o, sbadaddr_o;
  logic [31:0]     mepc_o, mcause_o, mbadaddr_o, dpc_o;
  logic [1:0]      priv_o, dbg_prv_o;
  logic [DCW-1:0]  dbg_cause_o;

  trap_entry_seq #(.XLEN(XLEN), .DCAUSE_W(DCW), .DBG_ROM(ROM), .DBG_EXC(EXC)) u_trap_entry_seq (.*);

  int n_chk = 0, n_err = 0;
  logic [31:0] sh_sepc = 0, sh_scause = 0, sh_sbad = 0, sh_mepc = 0;
  logic [31:0] sh_mcause = 0, sh_mbad = 0, sh_dpc = 0, e_pc = 0, e_st = 0;
  logic [DCW-1:0] sh_dcause = 0;
  logic [1:0] sh_dprv = 0, e_priv = 3;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R3 sepc"}, sepc_o, sh_sepc);
    chk({tag, " R3 scause"}, scause_o, sh_scause);
    chk({tag, " R3 sbad"}, sbadaddr_o, sh_sbad);
    chk({tag, " R6 mepc"}, mepc_o, sh_mepc);
    chk({tag, " R5 mcause"}, mcause_o, sh_mcause);
    chk({tag, " R5 mbad"}, mbadaddr_o, sh_mbad);
    chk({tag, " R6 dpc"}, dpc_o, sh_dpc);
    chk({tag, " R7 dcause"}, dbg_cause_o, sh_dcause);
    chk({tag, " R7 dprv"}, dbg_prv_o, sh_dprv);
    chk({tag, " R2 priv"}, priv_o, e_priv);
    chk({tag, " R4 status"}, status_o, e_st);
    chk({tag, " R6 next_pc"}, next_pc_o, e_pc);
  endtask

  task automatic run_trap(input logic [1:0] pr, input bit intr, input int idx,
                          input logic [31:0] ed, input logic [31:0] id,
                          input logic [DCW-1:0] dc, input bit av, input bit att,
                          input logic [31:0] st, input logic [31:0] epc,
                          input logic [31:0] addr);
    logic [31:0] cause, mask;
    bit deleg, bkpt;
    cause = {intr, 31'(idx)};
    mask  = intr ? id : ed;
    deleg = (pr == 0 || pr == 1) && idx < 32 && mask[idx[4:0]];
    bkpt  = !intr && idx == 3 && att;
    e_st  = st;
    if (bkpt) begin
      e_pc = ROM; e_priv = 3; sh_dpc = epc; sh_dcause = 1; sh_dprv = pr;
    end else if (deleg) begin
      e_pc = STVEC; sh_scause = cause; sh_sepc = epc;
      if (av) sh_sbad = addr;
      e_st[5] = st[pr]; e_st[8] = pr[0]; e_st[1] = 1'b0; e_priv = 1;
    end else begin
      e_st[7] = st[pr]; e_st[12:11] = pr; e_st[3] = 1'b0; e_priv = 3;
      sh_mcause = cause;
      if (av) sh_mbad = addr;
      if (dc != 0) begin e_pc = EXC; sh_dpc = epc; end
      else begin e_pc = MTVEC; sh_mepc = epc; end
    end
    @(negedge clk);
    trap_valid_i = 1; trap_cause_i = cause; cur_priv_i = pr; edeleg_i = ed;
    ideleg_i = id; dbg_cause_i = dc; trap_addr_valid_i = av;
    dbg_attached_i = att; status_i = st; trap_epc_i = epc; trap_addr_i = addr;
    @(negedge clk);
    trap_valid_i = 0;
    check_all(bkpt ? "R7 dbg" : deleg ? "R1 sup" : "R1 mach");
    chk("R8 redirect", redirect_o, 1);
    chk("R8 release", resv_release_o, 1);
    chk("R8 flush", tlb_flush_o, e_priv != pr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int cnt = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_all("R10 reset");
    chk("R10 pulses", {redirect_o, tlb_flush_o, resv_release_o}, 0);
    for (int p = 0; p < 3; p++)
      for (int intr = 0; intr < 2; intr++)
        for (int idx = 0; idx < 34; idx++)
          for (int mk = 0; mk < 2; mk++)
            for (int dv = 0; dv < 2; dv++) begin
              logic [1:0] pr;
              logic [31:0] st;
              pr = (p == 2) ? 2'd3 : 2'(p);
              st = 32'h1FFF & (32'(idx) * 32'h2F5 + 32'(p * 7 + mk * 13 + dv * 3));
              cnt++;
              run_trap(pr, intr[0], idx,
                       mk ? 32'hAAAA_5555 : 32'h0F0F_F0F0,
                       mk ? 32'h5555_AAAA : 32'hF0F0_0F0F,
                       dv ? 3'd2 : 3'd0, ((idx + mk + dv) & 1) == 1,
                       ((idx ^ mk) & 1) == 1, st,
                       32'h1000 + 32'(cnt) * 4, 32'hB000_0000 ^ 32'(cnt));
            end
    for (int i = 0; i < 5; i++) begin
      trap_epc_i = 32'hDEAD_0000 + 32'(i);
      cur_priv_i = 2'(i);
      @(negedge clk);
      check_all("R9 idle");
      chk("R9 pulses", {redirect_o, tlb_flush_o, resv_release_o}, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule